// File: doc/BRIEF.md
# Watermarked Audio Channel FIFO

This block sits between a host processor and one audio converter path and buffers 32-bit samples in both directions. In the capture direction the converter streams samples in and the host drains them by reading a data register. In the playback direction the host fills the FIFO by writing a data register and the converter streams samples out. Each direction has its own 512-entry store, a pair of programmable thresholds (almost-full and almost-empty), exact full and empty flags, and a readable read/write index pair, so software can work out fill level or free space.

Threshold crossings and overflows are latched into write-1-to-clear interrupt bits. Each bit has its own enable, and a single interrupt line is the OR of the enabled bits. A threshold can also drive a DMA request line instead of, or next to, the interrupt. A flush bit empties either direction at once.

Both streams follow valid/ready rules. On the capture input, `cap_in_ready` is low while the capture FIFO is full. A beat is taken only on a cycle where valid and ready are both high. A beat offered while the FIFO is full is not taken and counts as a capture overflow; the source may hold it or drop it. On the playback output, `pb_out_valid` is high whenever the playback FIFO holds data. `pb_out_data` stays stable until the cycle where `pb_out_ready` is high, and the entry is removed on that cycle.

The register port uses word indices on `reg_addr`. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`, and a read of the capture data register removes one entry on the edge where `reg_rd` is high.

Top module: `wm_audio_fifo`

## Requirements
- R1: After reset both FIFOs are empty, both index registers read 0, the status register reads 0xAA, every raw interrupt bit is 0, and `irq`, `cap_dma_req` and `pb_dma_req` are low.
- R2: A capture beat is taken only when `cap_in_valid` and `cap_in_ready` are both high, and `cap_in_ready` is low exactly while the capture FIFO is full. Host reads of index 1 return the taken beats in arrival order.
- R3: Each host write to index 0 enters the playback FIFO. `pb_out_valid` is high while the playback FIFO is not empty, and the words leave on `pb_out_data` in write order, one per cycle with valid and ready both high.
- R4: A FIFO holds exactly 512 words. A playback write while full is dropped and sets interrupt bit 5. A capture beat offered while full is refused and sets interrupt bit 4.
- R5: A host read of index 1 while the capture FIFO is empty returns 0 and leaves both capture indices unchanged.
- R6: Index registers (index 4 for capture, index 5 for playback) give the write index in bits [9:0] and the read index in bits [25:16]. Each index counts entries modulo 512.
- R7: The status register (index 6) has one nibble per direction: capture in bits [3:0] and playback in bits [7:4]. Within a nibble, bit 0 is full, bit 1 is empty, bit 2 is almost-full (level >= almost-full threshold), and bit 3 is almost-empty (level <= almost-empty threshold).
- R8: Threshold registers (index 2 for capture, index 3 for playback) hold the almost-full level in bits [8:0] and the almost-empty level in bits [24:16], and read back as written. Reset values are 511 and 0.
- R9: Raw interrupt bits (read at index 8) are, from bit 0 up: capture almost-empty, capture almost-full, playback almost-empty, playback almost-full, capture overflow, playback overflow. A threshold bit is set on the rising edge of its flag. Writing 1 to a bit at index 8 clears it, but a new event in the same cycle wins over the clear.
- R10: Index 9 reads raw AND enable, where the enables are at index 7. `irq` is high exactly when that masked value is nonzero.
- R11: Control index 10 bit 0 enables capture DMA and bit 1 enables playback DMA. `cap_dma_req` is capture almost-full gated by bit 0, and `pb_dma_req` is playback almost-empty gated by bit 1.
- R12: Writing index 10 with bit 2 (capture) or bit 3 (playback) set empties that FIFO and returns both of its indices to 0. A capture beat offered in the same cycle as a capture flush is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cap_in_valid | input | 1 | Capture beat offered by the converter |
| cap_in_ready | output | 1 | Capture FIFO can take a beat |
| cap_in_data | input | 32 | Capture sample |
| pb_out_valid | output | 1 | Playback sample available |
| pb_out_ready | input | 1 | Converter takes the playback sample |
| pb_out_data | output | 32 | Playback sample |
| cap_dma_req | output | 1 | Capture DMA request |
| pb_dma_req | output | 1 | Playback DMA request |
| irq | output | 1 | Interrupt, OR of enabled raw bits |

## Verification
Two cases can land in the same cycle. The first is a write-1-to-clear of the capture almost-full bit and the latch of a fresh rising edge on that bit. The bench pops the capture FIFO to one word below the threshold, then offers one beat. It issues the clear in the cycle right after that beat is taken, which is the cycle the new edge is being latched. The raw bit must read back as set; a clear issued alone afterwards must read it as zero. The second case is a capture flush issued in the same cycle a beat is offered. The flush must win: the FIFO ends empty with both indices at zero.

// File: rtl/wafifo_pkg.sv
package wafifo_pkg;

  // register word indices
  localparam logic [3:0] A_PB_DATA  = 4'd0;
  localparam logic [3:0] A_CAP_DATA = 4'd1;
  localparam logic [3:0] A_CAP_THR  = 4'd2;
  localparam logic [3:0] A_PB_THR   = 4'd3;
  localparam logic [3:0] A_CAP_PTR  = 4'd4;
  localparam logic [3:0] A_PB_PTR   = 4'd5;
  localparam logic [3:0] A_STATUS   = 4'd6;
  localparam logic [3:0] A_IRQ_EN   = 4'd7;
  localparam logic [3:0] A_IRQ_RAW  = 4'd8;
  localparam logic [3:0] A_IRQ_MSK  = 4'd9;
  localparam logic [3:0] A_CTRL     = 4'd10;

  // second field of a paired register starts here
  localparam int HI_FIELD = 16;

  // interrupt event positions (software decodes these)
  localparam int N_EV       = 6;
  localparam int EV_CAP_AE  = 0;
  localparam int EV_CAP_AF  = 1;
  localparam int EV_PB_AE   = 2;
  localparam int EV_PB_AF   = 3;
  localparam int EV_CAP_OVF = 4;
  localparam int EV_PB_OVF  = 5;

  // control bits
  localparam int CT_CAP_DMA   = 0;
  localparam int CT_PB_DMA    = 1;
  localparam int CT_CAP_FLUSH = 2;
  localparam int CT_PB_FLUSH  = 3;

  // per-direction flag nibble, bit 0 = full
  typedef struct packed {
    logic aempty;
    logic afull;
    logic empty;
    logic full;
  } dir_flags_t;

endpackage

// File: rtl/wafifo_core.sv
module wafifo_core
  import wafifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 push_data_i,
  input  logic                         pop_i,
  input  logic [$clog2(DEPTH)-1:0]     af_thr_i,
  input  logic [$clog2(DEPTH)-1:0]     ae_thr_i,
  output logic [W-1:0]                 head_o,
  output dir_flags_t                   flags_o,
  output logic                         af_rise_o,
  output logic                         ae_rise_o,
  output logic                         drop_o,
  output logic [$clog2(DEPTH)-1:0]     wr_idx_o,
  output logic [$clog2(DEPTH)-1:0]     rd_idx_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, level;
  logic          full, empty, afull, aempty;
  logic          push_ok, pop_ok;
  logic          af_prev_q, ae_prev_q;

  assign level   = wr_q - rd_q;
  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign afull   = (level >= {1'b0, af_thr_i});
  assign aempty  = (level <= {1'b0, ae_thr_i});
  assign push_ok = push_i && !full && !flush_i;
  assign pop_ok  = pop_i && !empty && !flush_i;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
    end
  end

  // previous flag values for edge detection; at reset level is 0,
  // which always satisfies the almost-empty compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_prev_q <= 1'b0;
      ae_prev_q <= 1'b1;
    end else begin
      af_prev_q <= afull;
      ae_prev_q <= aempty;
    end
  end

  assign head_o    = empty ? '0 : mem[rd_q[AW-1:0]];
  assign flags_o   = '{aempty: aempty, afull: afull, empty: empty, full: full};
  assign af_rise_o = afull && !af_prev_q;
  assign ae_rise_o = aempty && !ae_prev_q;
  assign drop_o    = push_i && full && !flush_i;
  assign wr_idx_o  = wr_q[AW-1:0];
  assign rd_idx_o  = rd_q[AW-1:0];

  assert_drop_keeps_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !flush_i) |=> $stable(wr_q));

  assert_empty_pop_keeps_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !flush_i) |=> $stable(rd_q));

  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (wr_q == '0 && rd_q == '0));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

endmodule

// File: rtl/wafifo_irq.sv
module wafifo_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         raw_q[i] <= 1'b0;
      else if (set_i[i])  raw_q[i] <= 1'b1;
      else if (clr_i[i])  raw_q[i] <= 1'b0;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & en_i;
  assign irq_o    = |masked_o;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));

  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/wm_audio_fifo.sv
module wm_audio_fifo
  import wafifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cap_in_valid,
  output logic              cap_in_ready,
  input  logic [DATA_W-1:0] cap_in_data,
  output logic              pb_out_valid,
  input  logic              pb_out_ready,
  output logic [DATA_W-1:0] pb_out_data,
  output logic              cap_dma_req,
  output logic              pb_dma_req,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] THR_MAX = AW'(DEPTH - 1);

  logic [AW-1:0]   cap_af_q, cap_ae_q, pb_af_q, pb_ae_q;
  logic [N_EV-1:0] irq_en_q;
  logic            cap_dma_q, pb_dma_q;

  logic            wr_ctrl, cap_flush, pb_flush, pb_push, cap_pop, pb_pop;
  logic [N_EV-1:0] ev_set, ev_clr, ev_raw, ev_msk;

  dir_flags_t      cap_flags, pb_flags;
  logic [DATA_W-1:0] cap_head, pb_head;
  logic [AW-1:0]   cap_wr_idx, cap_rd_idx, pb_wr_idx, pb_rd_idx;
  logic            cap_af_rise, cap_ae_rise, pb_af_rise, pb_ae_rise;
  logic            cap_drop, pb_drop;
  logic            unused_wdata;

  // decode
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign cap_flush = wr_ctrl && reg_wdata[CT_CAP_FLUSH];
  assign pb_flush  = wr_ctrl && reg_wdata[CT_PB_FLUSH];
  assign pb_push   = reg_wr && (reg_addr == A_PB_DATA);
  assign cap_pop   = reg_rd && (reg_addr == A_CAP_DATA);
  assign pb_pop    = pb_out_valid && pb_out_ready;
  assign ev_clr    = (reg_wr && (reg_addr == A_IRQ_RAW)) ? reg_wdata[N_EV-1:0] : '0;
  assign unused_wdata = ^reg_wdata;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_af_q  <= THR_MAX;
      cap_ae_q  <= '0;
      pb_af_q   <= THR_MAX;
      pb_ae_q   <= '0;
      irq_en_q  <= '0;
      cap_dma_q <= 1'b0;
      pb_dma_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CAP_THR: begin
          cap_af_q <= reg_wdata[0 +: AW];
          cap_ae_q <= reg_wdata[HI_FIELD +: AW];
        end
        A_PB_THR: begin
          pb_af_q <= reg_wdata[0 +: AW];
          pb_ae_q <= reg_wdata[HI_FIELD +: AW];
        end
        A_IRQ_EN: irq_en_q <= reg_wdata[N_EV-1:0];
        A_CTRL: begin
          cap_dma_q <= reg_wdata[CT_CAP_DMA];
          pb_dma_q  <= reg_wdata[CT_PB_DMA];
        end
        default: ;
      endcase
    end
  end

  // capture: converter pushes, host pops
  wafifo_core #(.W(DATA_W), .DEPTH(DEPTH)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (cap_flush),
    .push_i     (cap_in_valid),
    .push_data_i(cap_in_data),
    .pop_i      (cap_pop),
    .af_thr_i   (cap_af_q),
    .ae_thr_i   (cap_ae_q),
    .head_o     (cap_head),
    .flags_o    (cap_flags),
    .af_rise_o  (cap_af_rise),
    .ae_rise_o  (cap_ae_rise),
    .drop_o     (cap_drop),
    .wr_idx_o   (cap_wr_idx),
    .rd_idx_o   (cap_rd_idx)
  );

  // playback: host pushes, converter pops
  wafifo_core #(.W(DATA_W), .DEPTH(DEPTH)) u_pb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (pb_flush),
    .push_i     (pb_push),
    .push_data_i(reg_wdata),
    .pop_i      (pb_pop),
    .af_thr_i   (pb_af_q),
    .ae_thr_i   (pb_ae_q),
    .head_o     (pb_head),
    .flags_o    (pb_flags),
    .af_rise_o  (pb_af_rise),
    .ae_rise_o  (pb_ae_rise),
    .drop_o     (pb_drop),
    .wr_idx_o   (pb_wr_idx),
    .rd_idx_o   (pb_rd_idx)
  );

  always_comb begin
    ev_set             = '0;
    ev_set[EV_CAP_AE]  = cap_ae_rise;
    ev_set[EV_CAP_AF]  = cap_af_rise;
    ev_set[EV_PB_AE]   = pb_ae_rise;
    ev_set[EV_PB_AF]   = pb_af_rise;
    ev_set[EV_CAP_OVF] = cap_drop;
    ev_set[EV_PB_OVF]  = pb_drop;
  end

  wafifo_irq #(.N(N_EV)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev_set),
    .clr_i   (ev_clr),
    .en_i    (irq_en_q),
    .raw_o   (ev_raw),
    .masked_o(ev_msk),
    .irq_o   (irq)
  );

  // stream edges
  assign cap_in_ready = !cap_flags.full;
  assign pb_out_valid = !pb_flags.empty;
  assign pb_out_data  = pb_head;

  assign cap_dma_req = cap_dma_q && cap_flags.afull;
  assign pb_dma_req  = pb_dma_q && pb_flags.aempty;

  function automatic logic [DATA_W-1:0] pack_pair(input logic [AW-1:0] lo,
                                                  input logic [AW-1:0] hi);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0 +: AW] = lo;
    w[HI_FIELD +: AW] = hi;
    return w;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CAP_DATA: reg_rdata = cap_head;
      A_CAP_THR:  reg_rdata = pack_pair(cap_af_q, cap_ae_q);
      A_PB_THR:   reg_rdata = pack_pair(pb_af_q, pb_ae_q);
      A_CAP_PTR:  reg_rdata = pack_pair(cap_wr_idx, cap_rd_idx);
      A_PB_PTR:   reg_rdata = pack_pair(pb_wr_idx, pb_rd_idx);
      A_STATUS:   reg_rdata[7:0] = {pb_flags, cap_flags};
      A_IRQ_EN:   reg_rdata[N_EV-1:0] = irq_en_q;
      A_IRQ_RAW:  reg_rdata[N_EV-1:0] = ev_raw;
      A_IRQ_MSK:  reg_rdata[N_EV-1:0] = ev_msk;
      A_CTRL: begin
        reg_rdata[CT_CAP_DMA] = cap_dma_q;
        reg_rdata[CT_PB_DMA]  = pb_dma_q;
      end
      default: ;
    endcase
  end

  assert_ready_refuses_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_in_valid && !cap_in_ready && !cap_flush) |=> ev_raw[EV_CAP_OVF]);

endmodule

// File: tb/wm_audio_fifo_bench.sv
`timescale 1ns/1ps
module wm_audio_fifo_bench;
  localparam real HALF = 2.0;  // 250 MHz
  localparam logic [3:0] PB_DATA = 4'd0, CAP_DATA = 4'd1, CAP_THR = 4'd2,
    CAP_PTR = 4'd4, PB_PTR = 4'd5, STATUS = 4'd6, IRQ_EN = 4'd7,
    IRQ_RAW = 4'd8, IRQ_MSK = 4'd9, CTRL = 4'd10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cap_in_valid = 1'b0, cap_in_ready;
  logic [31:0] cap_in_data = '0;
  logic pb_out_valid, pb_out_ready = 1'b0;
  logic [31:0] pb_out_data;
  logic cap_dma_req, pb_dma_req, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] cap_q[$], pb_q[$];

  always #(HALF) clk = ~clk;

  wm_audio_fifo u_wm_audio_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_in_valid(cap_in_valid), .cap_in_ready(cap_in_ready),
    .cap_in_data(cap_in_data), .pb_out_valid(pb_out_valid),
    .pb_out_ready(pb_out_ready), .pb_out_data(pb_out_data),
    .cap_dma_req(cap_dma_req), .pb_dma_req(pb_dma_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a,
                        input logic [31:0] mask, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    chk(req, d & mask, exp);
  endtask

  // capture driver: offer n back-to-back beats, queue the taken ones
  task automatic cap_stream(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_in_valid = 1'b1; cap_in_data = base + 32'(i);
      #1 if (cap_in_ready) cap_q.push_back(cap_in_data);
    end
    @(negedge clk);
    cap_in_valid = 1'b0;
  endtask

  // capture monitor: host read compared with the scoreboard
  task automatic cap_pop_chk(input string req);
    logic [31:0] d, e;
    reg_read(CAP_DATA, d);
    e = (cap_q.size() != 0) ? cap_q.pop_front() : 32'h0;
    chk(req, d, e);
  endtask

  task automatic pb_put(input logic [31:0] d);
    reg_write(PB_DATA, d);
    pb_q.push_back(d);
  endtask

  // playback monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && pb_out_valid && pb_out_ready) begin
      if (pb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected beat act=%h exp=none", pb_out_data);
      end else begin
        chk("R3 playback order", pb_out_data, pb_q.pop_front());
      end
    end
  end

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd_chk("R1 status", STATUS, 32'hFFFF_FFFF, 32'h0000_00AA);
    rd_chk("R1 cap idx", CAP_PTR, 32'hFFFF_FFFF, 32'h0);
    rd_chk("R1 pb idx", PB_PTR, 32'hFFFF_FFFF, 32'h0);
    rd_chk("R1 raw", IRQ_RAW, 32'hFFFF_FFFF, 32'h0);
    chk("R1 outputs", {29'd0, irq, cap_dma_req, pb_dma_req}, 32'h0);

    // R2 capture order, R6 index layout, R5 empty read
    cap_stream(5, 32'hA000_0000);
    for (int i = 0; i < 5; i++) cap_pop_chk("R2 capture order");
    rd_chk("R6 cap idx", CAP_PTR, 32'hFFFF_FFFF, 32'h0005_0005);
    reg_read(CAP_DATA, d);
    chk("R5 empty read data", d, 32'h0);
    rd_chk("R5 idx unchanged", CAP_PTR, 32'hFFFF_FFFF, 32'h0005_0005);

    // R3 playback with back-pressure
    for (int i = 0; i < 4; i++) pb_put(32'hB000_0010 + 32'(i));
    tick(2);
    chk("R3 valid held", {31'd0, pb_out_valid}, 32'h1);
    chk("R3 head stable", pb_out_data, 32'hB000_0010);
    pb_out_ready = 1'b1;
    tick(6);
    chk("R3 drained", 32'(pb_q.size()), 32'h0);
    rd_chk("R6 pb idx", PB_PTR, 32'hFFFF_FFFF, 32'h0004_0004);

    // R8 / R7 / R9 / R10 thresholds and interrupts
    reg_write(IRQ_RAW, 32'h3F);
    rd_chk("R9 clear all", IRQ_RAW, 32'hFFFF_FFFF, 32'h0);
    reg_write(CTRL, 32'h4);
    cap_q.delete();
    reg_write(CAP_THR, 32'h0001_0003);
    rd_chk("R8 thr readback", CAP_THR, 32'hFFFF_FFFF, 32'h0001_0003);
    cap_stream(3, 32'hC000_0000);
    tick(1);
    rd_chk("R7 cap nibble af", STATUS, 32'hFF, 32'h0000_00A4);
    rd_chk("R9 af edge only", IRQ_RAW, 32'hFFFF_FFFF, 32'h0000_0002);
    rd_chk("R10 masked off", IRQ_MSK, 32'hFFFF_FFFF, 32'h0);
    chk("R10 irq low", {31'd0, irq}, 32'h0);
    reg_write(IRQ_EN, 32'h2);
    rd_chk("R10 masked on", IRQ_MSK, 32'hFFFF_FFFF, 32'h2);
    chk("R10 irq high", {31'd0, irq}, 32'h1);
    reg_write(IRQ_RAW, 32'h2);
    rd_chk("R9 w1c", IRQ_RAW, 32'h2, 32'h0);
    chk("R10 irq cleared", {31'd0, irq}, 32'h0);

    // R9 new event and clear in the same cycle: set wins
    cap_pop_chk("R2 capture order");
    @(negedge clk);
    cap_in_valid = 1'b1; cap_in_data = 32'hC000_0100;
    #1 if (cap_in_ready) cap_q.push_back(cap_in_data);
    @(negedge clk);
    cap_in_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = IRQ_RAW; reg_wdata = 32'h2;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R9 set beats clear", IRQ_RAW, 32'h2, 32'h2);
    reg_write(IRQ_RAW, 32'h2);
    rd_chk("R9 clear alone", IRQ_RAW, 32'h2, 32'h0);

    // R11 DMA requests
    chk("R11 cap dma off", {31'd0, cap_dma_req}, 32'h0);
    reg_write(CTRL, 32'h3);
    chk("R11 cap dma on", {31'd0, cap_dma_req}, 32'h1);
    chk("R11 pb dma on", {31'd0, pb_dma_req}, 32'h1);

    // R12 flush in the same cycle as a capture beat
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 32'h5;
    cap_in_valid = 1'b1; cap_in_data = 32'hDEAD_0001;
    @(negedge clk);
    reg_wr = 1'b0; cap_in_valid = 1'b0;
    cap_q.delete();
    rd_chk("R12 flushed status", STATUS, 32'hF, 32'hA);
    rd_chk("R12 flushed idx", CAP_PTR, 32'hFFFF_FFFF, 32'h0);
    chk("R12 dma drops", {31'd0, cap_dma_req}, 32'h0);

    // R4 capture fills to 512 and refuses
    cap_stream(512, 32'h1000_0000);
    chk("R4 cap took 512", 32'(cap_q.size()), 32'd512);
    @(negedge clk);
    cap_in_valid = 1'b1; cap_in_data = 32'hDEAD_0002;
    #1 chk("R2 ready low when full", {31'd0, cap_in_ready}, 32'h0);
    @(negedge clk);
    cap_in_valid = 1'b0;
    tick(1);
    rd_chk("R4 cap overflow bit", IRQ_RAW, 32'h10, 32'h10);
    rd_chk("R4 cap full flag", STATUS, 32'h1, 32'h1);
    for (int i = 0; i < 512; i++) cap_pop_chk("R2 capture order");
    reg_read(CAP_DATA, d);
    chk("R5 empty after drain", d, 32'h0);
    rd_chk("R6 wrapped idx", CAP_PTR, 32'hFFFF_FFFF, 32'h0);

    // R4 playback fills to 512, extra write dropped
    pb_out_ready = 1'b0;
    reg_write(CTRL, 32'hB);
    for (int i = 0; i < 512; i++) pb_put(32'h2000_0000 + 32'(i));
    rd_chk("R4 pb full flag", STATUS, 32'h10, 32'h10);
    reg_write(PB_DATA, 32'hDEAD_0003);
    tick(1);
    rd_chk("R4 pb overflow bit", IRQ_RAW, 32'h20, 32'h20);
    pb_out_ready = 1'b1;
    for (int i = 0; i < 1200 && pb_q.size() != 0; i++) @(negedge clk);
    tick(3);
    chk("R4 pb drained", 32'(pb_q.size()), 32'h0);
    chk("R4 dropped word absent", {31'd0, pb_out_valid}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule